// File: doc/BRIEF.md
# SMBus Block Transfer Byte Buffer

This block is the 32-byte store that sits behind the block-data port of an SMBus host controller. Software fills it one byte at a time through a single port that steps an internal pointer on every access, before a block write. It empties it the same way after a block read. The bus engine on the other side streams bytes out of the store onto the wire, or captures received bytes into it, through its own pointer that it resets at the start of each transaction. The byte count of a block travels in a separate length register. Software writes it before a block write, and the engine loads it from the wire on a block read.

Software rewinds its pointer by reading the host control register. That read arrives here as a one-cycle strobe. The same strobe clears a sticky flag that marks a received length outside 1 to 32. When the buffer-enable bit from the auxiliary control register is low, the block falls back to one-byte-at-a-time operation. In that mode every access goes to entry 0 and neither pointer moves.

The engine streams use valid/ready. A transmit byte is transferred on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, the engine pointer and `tx_data` hold. A receive byte is accepted on a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` drops once the buffer is full, and no other back-pressure is applied. The software side is plain one-cycle strobes. `sw_rd_data` is combinational from the current pointer and is valid during the cycle of `sw_rd`.

Top module: `smbus_blkbuf`

## Requirements
- R1: After reset, the length register reads 0, `len_err` is 0, `rx_ready` is 1 and, with buffer mode on, `tx_valid` is 0.
- R2: In buffer mode, each `sw_wr` strobe stores `sw_wdata` at the software pointer and advances the pointer by one.
- R3: In buffer mode, each `sw_rd` strobe presents the byte at the software pointer on `sw_rd_data` during that cycle and advances the pointer by one, so bytes come back in the order they were stored.
- R4: An `sw_ctrl_rd` strobe returns the software pointer to entry 0 on the next cycle.
- R5: With the software pointer at 32, a write is dropped and no stored entry changes. A read returns 0x00 and the pointer stays at 32.
- R6: `sw_len_wr` loads `sw_len_data` into the length register. `eng_len_valid` loads `eng_len_data` into it. When both arrive in the same cycle, the engine value wins.
- R7: An engine length load of 0 or of any value above 32 sets `len_err`. The flag stays set until an `sw_ctrl_rd` strobe, and a load of 1 to 32 never sets it.
- R8: In buffer mode, after `eng_start`, `tx_valid` is high exactly while the engine pointer is below a length of 1 to 32. `tx_data` gives entries 0, 1, 2 … in order, and the pointer advances only on a transfer.
- R9: In buffer mode, after `eng_start`, each accepted receive byte is stored at the engine pointer, which then advances. `rx_ready` is low once 32 bytes have been accepted.
- R10: With `buf_en` low, neither pointer moves. Software writes, software reads, engine receives and `tx_data` all use entry 0, and `tx_valid` and `rx_ready` are both held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_en | input | 1 | Buffer mode enable (auxiliary control bit) |
| sw_ctrl_rd | input | 1 | Strobe: software read of the host control register |
| sw_wr | input | 1 | Strobe: software write to the block-data port |
| sw_wdata | input | 8 | Byte written by software |
| sw_rd | input | 1 | Strobe: software read of the block-data port |
| sw_rd_data | output | 8 | Byte at the software pointer (0x00 at the end) |
| sw_len_wr | input | 1 | Strobe: software write of the length register |
| sw_len_data | input | 8 | Length written by software |
| eng_start | input | 1 | Engine transaction start, clears the engine pointer |
| eng_len_valid | input | 1 | Engine loads a received length |
| eng_len_data | input | 8 | Received length |
| len | output | 8 | Current length register |
| len_err | output | 1 | Sticky invalid-length flag |
| tx_valid | output | 1 | Transmit byte available to the engine |
| tx_ready | input | 1 | Engine takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_ready | output | 1 | Buffer can accept a received byte |
| rx_data | input | 8 | Received byte |

## Verification
Several properties are checked on every cycle. The software pointer is bounded and returns to zero after a control read. A read at the end gives zero. The error flag rises on a bad length and persists. A valid transmit implies a legal length. A full buffer refuses receive bytes. Pointers are frozen in byte mode. The scenarios are needed for the data itself: bytes round-trip in order through both ports, the engine drains under random back-pressure, a dropped write at the end leaves entry 0 untouched, and length writes from both sides collide in the same cycle.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  localparam int unsigned SBB_DEPTH = 32;
  localparam int unsigned SBB_DW    = 8;
endpackage

// File: rtl/sbb_index.sv
module sbb_index #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned IW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LIMIT = IW'(DEPTH);

  // saturating pointer: stops at DEPTH, clear has priority
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   idx <= '0;
    else if (clr)                 idx <= '0;
    else if (adv && idx < LIMIT)  idx <= idx + 1'b1;
  end
endmodule

// File: rtl/sbb_store.sv
module sbb_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] d_a,
  output logic [DW-1:0] q_a,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] d_b,
  output logic [DW-1:0] q_b
);
  logic [DW-1:0] mem [DEPTH];

  // one flop row per entry; port b (engine) wins a same-entry collision
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              mem[e] <= '0;
      else if (we_b && addr_b == AW'(e))       mem[e] <= d_b;
      else if (we_a && addr_a == AW'(e))       mem[e] <= d_a;
    end
  end

  assign q_a = mem[addr_a];
  assign q_b = mem[addr_b];
endmodule

// File: rtl/sbb_length.sv
module sbb_length #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_wr,
  input  logic [DW-1:0] sw_d,
  input  logic          eng_ld,
  input  logic [DW-1:0] eng_d,
  input  logic          clr_err,
  output logic [DW-1:0] len_q,
  output logic          err_q
);
  localparam logic [DW-1:0] LIMIT = DW'(DEPTH);
  logic bad;

  assign bad = eng_ld && (eng_d == '0 || eng_d > LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (eng_ld) len_q <= eng_d;
    else if (sw_wr)  len_q <= sw_d;
  end

  // a new violation in the clearing cycle still sets the flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (bad)     err_q <= 1'b1;
    else if (clr_err) err_q <= 1'b0;
  end
endmodule

// File: rtl/smbus_blkbuf.sv
module smbus_blkbuf
  import sbb_pkg::*;
#(
  parameter int unsigned DEPTH = SBB_DEPTH,
  parameter int unsigned DW    = SBB_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_en,
  input  logic          sw_ctrl_rd,
  input  logic          sw_wr,
  input  logic [DW-1:0] sw_wdata,
  input  logic          sw_rd,
  output logic [DW-1:0] sw_rd_data,
  input  logic          sw_len_wr,
  input  logic [DW-1:0] sw_len_data,
  input  logic          eng_start,
  input  logic          eng_len_valid,
  input  logic [DW-1:0] eng_len_data,
  output logic [DW-1:0] len,
  output logic          len_err,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data
);
  localparam int unsigned IW = $clog2(DEPTH + 1);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [IW-1:0] LIMIT = IW'(DEPTH);

  logic [IW-1:0] sw_idx, eng_idx;
  logic [AW-1:0] sw_addr, eng_addr;
  logic [DW-1:0] q_sw, q_eng;
  logic          sw_at_end, eng_at_end, sw_we, sw_adv;
  logic          tx_fire, rx_fire, eng_adv, len_ok;

  assign sw_at_end  = (sw_idx == LIMIT);
  assign eng_at_end = (eng_idx == LIMIT);

  // byte mode pins both ports to entry 0
  assign sw_addr  = buf_en ? sw_idx[AW-1:0]  : '0;
  assign eng_addr = buf_en ? eng_idx[AW-1:0] : '0;

  assign sw_we  = sw_wr && !(buf_en && sw_at_end);
  assign sw_adv = buf_en && (sw_wr || sw_rd);

  assign len_ok   = (len != '0) && (int'(len) <= int'(DEPTH));
  assign tx_valid = buf_en ? (len_ok && int'(eng_idx) < int'(len)) : 1'b1;
  assign rx_ready = buf_en ? !eng_at_end : 1'b1;
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_fire  = rx_valid && rx_ready;
  assign eng_adv  = buf_en && (tx_fire || rx_fire);

  assign sw_rd_data = (buf_en && sw_at_end) ? '0 : q_sw;
  assign tx_data    = q_eng;

  sbb_index #(.DEPTH(DEPTH), .IW(IW)) u_sw_ptr (
    .clk(clk), .rst_n(rst_n), .clr(sw_ctrl_rd), .adv(sw_adv), .idx(sw_idx)
  );

  sbb_index #(.DEPTH(DEPTH), .IW(IW)) u_eng_ptr (
    .clk(clk), .rst_n(rst_n), .clr(eng_start), .adv(eng_adv), .idx(eng_idx)
  );

  sbb_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we_a(sw_we), .addr_a(sw_addr), .d_a(sw_wdata), .q_a(q_sw),
    .we_b(rx_fire), .addr_b(eng_addr), .d_b(rx_data), .q_b(q_eng)
  );

  sbb_length #(.DEPTH(DEPTH), .DW(DW)) u_len (
    .clk(clk), .rst_n(rst_n),
    .sw_wr(sw_len_wr), .sw_d(sw_len_data),
    .eng_ld(eng_len_valid), .eng_d(eng_len_data),
    .clr_err(sw_ctrl_rd), .len_q(len), .err_q(len_err)
  );
endmodule

// File: rtl/sbb_chk.sv
module sbb_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  parameter int unsigned IW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          buf_en,
  input logic          sw_ctrl_rd,
  input logic          eng_start,
  input logic          eng_len_valid,
  input logic [DW-1:0] eng_len_data,
  input logic [IW-1:0] sw_idx,
  input logic [IW-1:0] eng_idx,
  input logic [DW-1:0] sw_rd_data,
  input logic [DW-1:0] len,
  input logic          len_err,
  input logic          tx_valid,
  input logic          rx_ready
);
  localparam logic [IW-1:0] LIM  = IW'(DEPTH);
  localparam logic [DW-1:0] LIML = DW'(DEPTH);

  // R4
  ctrl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ctrl_rd |=> sw_idx == '0);

  // R5
  sw_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_idx <= LIM);

  // R5
  end_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && sw_idx == LIM) |-> sw_rd_data == '0);

  // R7
  bad_len_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_len_valid && (eng_len_data == '0 || eng_len_data > LIML)) |=> len_err);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_err && !sw_ctrl_rd) |=> len_err);

  // R8
  tx_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && tx_valid) |-> (len != '0 && len <= LIML));

  // R9
  rx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && eng_idx == LIM) |-> !rx_ready);

  // R10
  byte_mode_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en && !sw_ctrl_rd && !eng_start) |=> ($stable(sw_idx) && $stable(eng_idx)));
endmodule

bind smbus_blkbuf sbb_chk #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .sw_ctrl_rd(sw_ctrl_rd),
  .eng_start(eng_start), .eng_len_valid(eng_len_valid),
  .eng_len_data(eng_len_data), .sw_idx(sw_idx), .eng_idx(eng_idx),
  .sw_rd_data(sw_rd_data), .len(len), .len_err(len_err),
  .tx_valid(tx_valid), .rx_ready(rx_ready)
);

// File: tb/tb_smbus_blkbuf.sv
`timescale 1ns/1ps
module tb_smbus_blkbuf;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic buf_en = 1'b1, sw_ctrl_rd = 1'b0, sw_wr = 1'b0, sw_rd = 1'b0;
  logic sw_len_wr = 1'b0, eng_start = 1'b0, eng_len_valid = 1'b0;
  logic tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0] sw_wdata = '0, sw_len_data = '0, eng_len_data = '0, rx_data = '0;
  logic [7:0] sw_rd_data, len, tx_data;
  logic len_err, tx_valid, rx_ready;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [DEPTH];

  always #2.5 clk = ~clk;

  smbus_blkbuf dut (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .sw_ctrl_rd(sw_ctrl_rd),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rd(sw_rd), .sw_rd_data(sw_rd_data),
    .sw_len_wr(sw_len_wr), .sw_len_data(sw_len_data), .eng_start(eng_start),
    .eng_len_valid(eng_len_valid), .eng_len_data(eng_len_data), .len(len),
    .len_err(len_err), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit len_bad(input int l);
    return (l == 0) || (l > DEPTH);
  endfunction

  task automatic ctrl_read();
    @(negedge clk) sw_ctrl_rd = 1'b1;
    @(negedge clk) sw_ctrl_rd = 1'b0;
  endtask

  task automatic sw_write(input logic [7:0] b);
    @(negedge clk) begin sw_wr = 1'b1; sw_wdata = b; end
    @(negedge clk) sw_wr = 1'b0;
  endtask

  task automatic sw_read(output logic [7:0] b);
    @(negedge clk) sw_rd = 1'b1;
    #1 b = sw_rd_data;
    @(negedge clk) sw_rd = 1'b0;
  endtask

  task automatic eng_go();
    @(negedge clk) eng_start = 1'b1;
    @(negedge clk) eng_start = 1'b0;
  endtask

  task automatic sw_len(input logic [7:0] l);
    @(negedge clk) begin sw_len_wr = 1'b1; sw_len_data = l; end
    @(negedge clk) sw_len_wr = 1'b0;
  endtask

  task automatic eng_len(input logic [7:0] l);
    @(negedge clk) begin eng_len_valid = 1'b1; eng_len_data = l; end
    @(negedge clk) eng_len_valid = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b, output logic acc);
    @(negedge clk) begin rx_valid = 1'b1; rx_data = b; end
    #1 acc = rx_ready;
    @(negedge clk) rx_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    int k = 0;
    int guard = 0;
    while (k < n && guard < 1000) begin
      @(negedge clk) tx_ready = 1'($urandom % 2);
      #1;
      chk(tx_valid == 1'b1, "R8 tx_valid while bytes remain", int'(tx_valid), 1);
      if (tx_valid && tx_ready) begin
        chk(tx_data == exp_mem[k], "R8 tx order", int'(tx_data), int'(exp_mem[k]));
        k++;
      end
      guard++;
    end
    @(negedge clk) tx_ready = 1'b0;
    #1 chk(tx_valid == 1'b0, "R8 tx_valid low after length", int'(tx_valid), 0);
  endtask

  initial begin
    logic [7:0] b;
    logic acc;
    void'($urandom(32'h5EED_0B1C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    chk(len == 8'd0, "R1 len reset", int'(len), 0);
    chk(len_err == 1'b0, "R1 err reset", int'(len_err), 0);
    chk(tx_valid == 1'b0, "R1 tx_valid reset", int'(tx_valid), 0);
    chk(rx_ready == 1'b1, "R1 rx_ready reset", int'(rx_ready), 1);

    // R2 R3 R8: random block writes, read back and engine drain
    for (int r = 0; r < 20; r++) begin
      int n = 1 + int'($urandom % DEPTH);
      ctrl_read();
      for (int i = 0; i < n; i++) begin
        exp_mem[i] = 8'($urandom);
        sw_write(exp_mem[i]);
      end
      sw_len(8'(n));
      @(negedge clk); #1 chk(len == 8'(n), "R6 sw length write", int'(len), n);
      ctrl_read();
      for (int i = 0; i < n; i++) begin
        sw_read(b);
        chk(b == exp_mem[i], "R3 R2 readback", int'(b), int'(exp_mem[i]));
      end
      eng_go();
      drain(n);
    end

    // R5: fill all entries, extra write dropped, reads at end give zero
    ctrl_read();
    for (int i = 0; i < DEPTH; i++) begin
      exp_mem[i] = 8'($urandom);
      sw_write(exp_mem[i]);
    end
    sw_write(8'hEE);
    sw_read(b); chk(b == 8'h00, "R5 read at end", int'(b), 0);
    sw_read(b); chk(b == 8'h00, "R5 read at end stays", int'(b), 0);
    ctrl_read();
    // R4
    for (int i = 0; i < DEPTH; i++) begin
      sw_read(b);
      chk(b == exp_mem[i], "R5 R4 no wrap on dropped write", int'(b), int'(exp_mem[i]));
    end

    // R9: engine receive, software readback, full back-pressure
    for (int r = 0; r < 6; r++) begin
      int n = 1 + int'($urandom % DEPTH);
      eng_go();
      eng_len(8'(n));
      chk(len_err == 1'b0, "R7 valid length no error", int'(len_err), 0);
      for (int i = 0; i < n; i++) begin
        exp_mem[i] = 8'($urandom);
        rx_push(exp_mem[i], acc);
        chk(acc == 1'b1, "R9 rx_ready before full", int'(acc), 1);
      end
      ctrl_read();
      for (int i = 0; i < n; i++) begin
        sw_read(b);
        chk(b == exp_mem[i], "R9 rx readback", int'(b), int'(exp_mem[i]));
      end
    end
    eng_go();
    for (int i = 0; i < DEPTH; i++) rx_push(8'(i), acc);
    @(negedge clk); #1 chk(rx_ready == 1'b0, "R9 rx_ready low when full", int'(rx_ready), 0);

    // R7: invalid lengths
    ctrl_read();
    for (int v = 0; v < 6; v++) begin
      int l = (v == 0) ? 0 : (v == 1) ? 33 : (v == 2) ? 255 :
              (v == 3) ? 1 : (v == 4) ? 32 : 34 + int'($urandom % 200);
      eng_len(8'(l));
      repeat (3) @(negedge clk);
      #1 chk(len_err == len_bad(l), "R7 length check", int'(len_err), int'(len_bad(l)));
      ctrl_read();
      #1 chk(len_err == 1'b0, "R7 cleared by control read", int'(len_err), 0);
    end

    // R6: same-cycle collision, engine value wins
    @(negedge clk) begin
      sw_len_wr = 1'b1; sw_len_data = 8'd7;
      eng_len_valid = 1'b1; eng_len_data = 8'd19;
    end
    @(negedge clk) begin sw_len_wr = 1'b0; eng_len_valid = 1'b0; end
    #1 chk(len == 8'd19, "R6 engine length priority", int'(len), 19);

    // R10: byte mode uses entry 0 only
    ctrl_read();
    @(negedge clk) buf_en = 1'b0;
    sw_write(8'hA1);
    sw_write(8'hB2);
    #1 chk(tx_valid == 1'b1 && rx_ready == 1'b1, "R10 byte mode handshake",
           int'({tx_valid, rx_ready}), 3);
    chk(tx_data == 8'hB2, "R10 tx_data entry 0", int'(tx_data), 'hB2);
    sw_read(b); chk(b == 8'hB2, "R10 read entry 0", int'(b), 'hB2);
    sw_read(b); chk(b == 8'hB2, "R10 read again no advance", int'(b), 'hB2);
    rx_push(8'hC3, acc);
    sw_read(b); chk(b == 8'hC3, "R10 rx into entry 0", int'(b), 'hC3);
    @(negedge clk) buf_en = 1'b1;
    sw_read(b); chk(b == 8'hC3, "R10 pointer stayed at 0", int'(b), 'hC3);
    sw_read(b); chk(b == 8'd1, "R10 entry 1 untouched", int'(b), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule